// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Unit

This block is a square grid of N x N multiply-accumulate cells. Each cell keeps one weight of a weight tile. Every clock cycle the block can take one vector of N 8-bit activations. After a fixed fill and drain latency it returns one vector of N column sums, one sum per output column, to an external accumulator. Inside the grid the activations travel as a diagonal wave. Row i is delayed i cycles on entry, and column j is re-aligned by N-1-j cycles on exit. From outside, each input vector therefore produces one aligned result vector. A batch of B vectors takes B issue cycles plus that latency.

Every cell holds two weight registers. One register belongs to the active tile and the other to the shadow tile. A new tile is written into the shadow bank one row per cycle while compute goes on with the active bank. A swap request makes the shadow bank the active one. The swap is accepted only between batches, so every vector of a batch is multiplied by the same tile. Each operand has a mode bit that selects whether it is read as a signed or an unsigned 8-bit integer: one bit per activation vector and one bit per loaded weight row. Each vector carries its tile selection through the grid. A swap therefore never changes the results of vectors that are already inside the array.

Top module: `wsa_matrix_unit`

## Requirements
- R1: During and after reset, out_valid is 0 and out_vec is all zero. Both weight tiles are clear, so a vector sent before any tile is loaded gives all-zero sums.
- R2: For an input vector with elements x_i = in_vec[8i+:8], the result out_vec[ACC_W*j +: ACC_W] equals the sum over i of x_i * W[i][j]. W[i][j] is element j (w_row[8j+:8]) of the i-th row loaded into the tile the vector used.
- R3: A vector sampled with in_valid=1 at a rising edge gives out_valid=1 with its result in the cycle after the (2N-1)-th rising edge, counting that edge as the first. Each vector gives exactly one result cycle, in issue order, and back-to-back vectors give back-to-back results.
- R4: With in_signed=1, every element of that vector is read as two's complement (-128..127); with in_signed=0 it is read as 0..255. w_signed applies the same rule to the weight row loaded in its cycle.
- R5: Column sums are exact ACC_W-bit two's-complement values with no wrap. With N=4 and ACC_W=32: all -128 by -128 gives 65536, -128 weights by 255 activations gives -130560, and 255 by 255 gives 260100.
- R6: Each cycle with w_load_valid=1 writes one row into the shadow tile, in row order 0..N-1 and wrapping after N-1. Results from the active tile do not change during loading. A load must not occur in the cycle a swap is accepted or in the 2N-2 cycles after it.
- R7: A batch opens with in_valid=1, in_last=0 and closes with in_valid=1, in_last=1. A swap_req pulse is accepted at its edge when no batch is open and in_valid=0, or when in_valid=1 with in_last=1. Vectors sampled at or before the accepting edge use the old tile, and later vectors use the newly loaded tile.
- R8: A swap requested while a batch is open, including on the batch's first vector and in idle gaps inside it, is held. It is accepted with the batch's last vector and is never lost.
- R9: out_vec is all zero in every cycle where out_valid is 0.
- R10: The shadow row counter restarts at row 0 whenever a swap is accepted, even if fewer than N rows were loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An activation vector is presented this cycle |
| in_last | input | 1 | The presented vector closes its batch |
| in_signed | input | 1 | Activation elements are two's complement when 1 |
| in_vec | input | N*8 | Activation vector; element i drives grid row i |
| swap_req | input | 1 | Request to make the shadow tile active |
| w_load_valid | input | 1 | Write one weight row into the shadow tile |
| w_signed | input | 1 | The loaded weight row is two's complement when 1 |
| w_row | input | N*8 | Weight row; element j goes to grid column j |
| out_valid | output | 1 | A result vector is present on out_vec |
| out_vec | output | N*ACC_W | Column sums; column j in slice j |

## Verification
The bench builds the unit with N=4 and ACC_W=32. At this size the full 2N-1 cycle wave, each skew and de-skew depth from 0 to 3, and a row counter that wraps after four rows can all be followed cycle by cycle. Four-term sums of extreme 8-bit operands exceed 16 bits but stay well inside 32, so the absence of wrap shows directly in the results. The small grid also lets a partial two-row tile and a held swap across an idle gap inside a batch be set up in a few dozen cycles.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

   localparam int unsigned OP_W   = 8;
   localparam int unsigned XOP_W  = OP_W + 1;
   localparam int unsigned PROD_W = 2 * XOP_W;

   // Widen an 8-bit operand into a 9-bit two's-complement value.
   function automatic logic [XOP_W-1:0] widen_op(input logic [OP_W-1:0] v,
                                                input logic            as_signed);
      return {as_signed & v[OP_W-1], v};
   endfunction

endpackage

// File: rtl/wsa_delay.sv
module wsa_delay #(
   parameter int W     = 32,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (W < 1) begin : g_chk_w
      $error("wsa_delay: W must be at least 1");
   end
   if (DEPTH < 0) begin : g_chk_d
      $error("wsa_delay: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_wire
      assign dout = din;
   end else begin : g_regs
      logic [W-1:0] stage [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
         end else begin
            stage[0] <= din;
            for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
         end
      end
      assign dout = stage[DEPTH-1];
   end

endmodule

// File: rtl/wsa_row_feed.sv
// Skews one activation row by ROW cycles, then hands it from column to column.
module wsa_row_feed #(
   parameter int N   = 8,
   parameter int ROW = 0,
   parameter int W   = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [W-1:0]        din,
   output logic [N-1:0][W-1:0] taps
);

   localparam int L = ROW + N - 1;

   if (ROW < 0 || ROW >= N) begin : g_chk_row
      $error("wsa_row_feed: ROW out of range");
   end
   if (N < 2) begin : g_chk_n
      $error("wsa_row_feed: N must be at least 2");
   end

   logic [W-1:0] stg [L];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < L; k++) stg[k] <= '0;
      end else begin
         stg[0] <= din;
         for (int k = 1; k < L; k++) stg[k] <= stg[k-1];
      end
   end

   for (genvar j = 0; j < N; j++) begin : g_tap
      if (ROW + j == 0) begin : g_direct
         assign taps[j] = din;
      end else begin : g_late
         assign taps[j] = stg[ROW+j-1];
      end
   end

endmodule

// File: rtl/wsa_cell.sv
module wsa_cell
   import wsa_pkg::*;
#(
   parameter int ACC_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [XOP_W-1:0] a_in,
   input  logic                    sel_in,
   input  logic [ACC_W-1:0]        psum_in,
   input  logic                    w_we,
   input  logic                    w_bank,
   input  logic signed [XOP_W-1:0] w_data,
   output logic [ACC_W-1:0]        psum_out
);

   if (ACC_W < PROD_W) begin : g_chk_acc
      $error("wsa_cell: ACC_W narrower than a product");
   end

   logic signed [XOP_W-1:0]  w_q [2];
   logic signed [XOP_W-1:0]  w_act;
   logic signed [PROD_W-1:0] prod;

   always_comb begin
      w_act = w_q[sel_in];
      prod  = a_in * w_act;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q[0]   <= '0;
         w_q[1]   <= '0;
         psum_out <= '0;
      end else begin
         if (w_we) w_q[w_bank] <= w_data;
         psum_out <= psum_in + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
      end
   end

   // R2: a zero activation passes the incoming partial sum on unchanged
   p_zero_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (a_in == '0) |=> (psum_out == $past(psum_in)));

endmodule

// File: rtl/wsa_tile_ctrl.sv
module wsa_tile_ctrl #(
   parameter int N = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_last,
   input  logic                 swap_req,
   input  logic                 w_load_valid,
   output logic                 sel_cur,
   output logic [$clog2(N)-1:0] row_cnt,
   output logic                 out_valid
);

   localparam int LAT   = 2 * N - 1;
   localparam int DRAIN = 2 * N - 2;
   localparam int RW    = $clog2(N);
   localparam int DW    = $clog2(DRAIN + 1);

   if (N < 2) begin : g_chk_n
      $error("wsa_tile_ctrl: N must be at least 2");
   end

   logic           in_batch_q;
   logic           swap_pend;
   logic           want;
   logic           accept;
   logic [DW-1:0]  drain_cnt;
   logic [LAT-1:0] vpipe;

   always_comb begin
      want   = swap_req | swap_pend;
      accept = want & (in_valid ? in_last : ~in_batch_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_batch_q <= 1'b0;
         swap_pend  <= 1'b0;
         sel_cur    <= 1'b0;
         row_cnt    <= '0;
         drain_cnt  <= '0;
         vpipe      <= '0;
      end else begin
         if (in_valid) in_batch_q <= ~in_last;
         swap_pend <= want & ~accept;
         sel_cur   <= sel_cur ^ accept;
         if (accept) begin
            row_cnt <= '0;
         end else if (w_load_valid) begin
            row_cnt <= (row_cnt == RW'(N-1)) ? '0 : row_cnt + 1'b1;
         end
         if (accept) begin
            drain_cnt <= DW'(DRAIN);
         end else if (drain_cnt != '0) begin
            drain_cnt <= drain_cnt - 1'b1;
         end
         vpipe <= {vpipe[LAT-2:0], in_valid};
      end
   end

   assign out_valid = vpipe[LAT-1];

   // R8: the active tile flips only at a batch boundary
   p_swap_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_cur) |-> $past(in_valid ? in_last : ~in_batch_q));

   // R7: a swap request is either taken or remembered
   p_swap_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      swap_req |=> (swap_pend || !$stable(sel_cur)));

   // R6: the shadow bank is written only once the old wave has drained
   p_shadow_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
      w_load_valid |-> (drain_cnt == '0 && !accept));

endmodule

// File: rtl/wsa_matrix_unit.sv
module wsa_matrix_unit
   import wsa_pkg::*;
#(
   parameter int N     = 8,
   parameter int ACC_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_last,
   input  logic               in_signed,
   input  logic [N*OP_W-1:0]  in_vec,
   input  logic               swap_req,
   input  logic               w_load_valid,
   input  logic               w_signed,
   input  logic [N*OP_W-1:0]  w_row,
   output logic               out_valid,
   output logic [N*ACC_W-1:0] out_vec
);

   localparam int RW  = $clog2(N);
   localparam int FDW = XOP_W + 1;

   if (N < 2) begin : g_chk_n
      $error("wsa_matrix_unit: N must be at least 2");
   end
   if (ACC_W < PROD_W + $clog2(N)) begin : g_chk_acc
      $error("wsa_matrix_unit: ACC_W too narrow for an N-term column sum");
   end

   logic          sel_cur;
   logic [RW-1:0] row_cnt;

   wsa_tile_ctrl #(.N(N)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_last      (in_last),
      .swap_req     (swap_req),
      .w_load_valid (w_load_valid),
      .sel_cur      (sel_cur),
      .row_cnt      (row_cnt),
      .out_valid    (out_valid)
   );

   logic [N-1:0][XOP_W-1:0] w_x;
   logic [N-1:0]            row_we;
   logic [ACC_W-1:0]        psum [N+1][N];

   for (genvar j = 0; j < N; j++) begin : g_col_in
      assign w_x[j]     = widen_op(w_row[j*OP_W +: OP_W], w_signed);
      assign psum[0][j] = '0;
   end

   for (genvar i = 0; i < N; i++) begin : g_row
      logic [XOP_W-1:0]      act_x;
      logic [N-1:0][FDW-1:0] taps_r;

      assign act_x     = in_valid ? widen_op(in_vec[i*OP_W +: OP_W], in_signed) : '0;
      assign row_we[i] = w_load_valid && (row_cnt == RW'(i));

      wsa_row_feed #(.N(N), .ROW(i), .W(FDW)) u_feed (
         .clk   (clk),
         .rst_n (rst_n),
         .din   ({sel_cur, act_x}),
         .taps  (taps_r)
      );

      for (genvar j = 0; j < N; j++) begin : g_cell
         wsa_cell #(.ACC_W(ACC_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_in     (taps_r[j][XOP_W-1:0]),
            .sel_in   (taps_r[j][XOP_W]),
            .psum_in  (psum[i][j]),
            .w_we     (row_we[i]),
            .w_bank   (~sel_cur),
            .w_data   (w_x[j]),
            .psum_out (psum[i+1][j])
         );
      end
   end

   for (genvar j = 0; j < N; j++) begin : g_deskew
      wsa_delay #(.W(ACC_W), .DEPTH(N-1-j)) u_dsk (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (psum[N][j]),
         .dout  (out_vec[j*ACC_W +: ACC_W])
      );
   end

   // R9: idle wave slots carry zeros through the whole grid
   p_quiet_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_vec == '0));

endmodule

// File: tb/wsa_matrix_unit_tb.sv
`timescale 1ns/1ps
module wsa_matrix_unit_tb;

   localparam int N   = 4;
   localparam int ACC = 32;
   localparam int LAT = 2 * N - 1;
   localparam int QD  = 64;

   typedef struct packed {
      logic        vld;
      logic [31:0] vec;
      logic        sgn;
      logic        last;
      logic        swp;
   } stim_t;

   // vld, vector, signed, last, swap
   localparam stim_t TBL [12] = '{
      '{1'b1, 32'h01020304, 1'b0, 1'b0, 1'b0},
      '{1'b1, 32'hFF80017F, 1'b1, 1'b0, 1'b0},
      '{1'b1, 32'h807F00FF, 1'b0, 1'b0, 1'b0},
      '{1'b1, 32'h10F0E020, 1'b1, 1'b0, 1'b1},
      '{1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0},
      '{1'b1, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0},
      '{1'b1, 32'h05060708, 1'b0, 1'b1, 1'b0},
      '{1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0},
      '{1'b1, 32'h80808080, 1'b1, 1'b0, 1'b0},
      '{1'b1, 32'h7F7F7F7F, 1'b1, 1'b0, 1'b0},
      '{1'b1, 32'hFEDCBA98, 1'b0, 1'b0, 1'b0},
      '{1'b1, 32'h00000001, 1'b1, 1'b1, 1'b0}
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             in_valid, in_last, in_signed, swap_req, w_load_valid, w_signed;
   logic [N*8-1:0]   in_vec, w_row;
   logic             out_valid;
   logic [N*ACC-1:0] out_vec;

   wsa_matrix_unit #(.N(N), .ACC_W(ACC)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_last (in_last), .in_signed (in_signed), .in_vec (in_vec),
      .swap_req (swap_req), .w_load_valid (w_load_valid), .w_signed (w_signed),
      .w_row (w_row), .out_valid (out_valid), .out_vec (out_vec)
   );

   always #2.5 clk = ~clk;

   int total = 0;
   int bad   = 0;
   int cnt   = 0;
   bit mon_on = 1'b0;

   always @(posedge clk) cnt++;

   // bench model of the two tiles and of the swap rules
   int bw [2][N][N];
   int act_t = 0, mrow = 0;
   bit mpend = 1'b0, mbatch = 1'b0;

   logic [N*ACC-1:0] exp_q [QD];
   int               due_q [QD];
   string            tag_q [QD];
   int               head = 0, tail = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [N*ACC-1:0] got, input logic [N*ACC-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   function automatic int xt(input logic [7:0] b, input bit s);
      return s ? int'($signed(b)) : int'(b);
   endfunction

   function automatic logic [N*ACC-1:0] model(input logic [N*8-1:0] v, input bit s, input int t);
      logic [N*ACC-1:0] r;
      for (int j = 0; j < N; j++) begin
         int sum = 0;
         for (int i = 0; i < N; i++) sum += xt(v[8*i +: 8], s) * bw[t][i][j];
         r[j*ACC +: ACC] = sum;
      end
      return r;
   endfunction

   function automatic logic [N*8-1:0] row_a(input int i);
      logic [N*8-1:0] r;
      for (int j = 0; j < N; j++) begin
         int v = (i * 4 + j) * 9 - 70;
         r[8*j +: 8] = v[7:0];
      end
      return r;
   endfunction

   function automatic logic [N*8-1:0] row_b(input int i);
      logic [N*8-1:0] r;
      for (int j = 0; j < N; j++) begin
         int v = 130 + 17 * i + 11 * j;
         r[8*j +: 8] = v[7:0];
      end
      return r;
   endfunction

   function automatic logic [N*8-1:0] row_q(input int i);
      logic [N*8-1:0] r;
      for (int j = 0; j < N; j++) begin
         int v = i * 5 + 1 + j;
         r[8*j +: 8] = v[7:0];
      end
      return r;
   endfunction

   task automatic step(input bit vld, input logic [N*8-1:0] vec, input bit sgn,
                       input bit last, input bit swp, input bit ld,
                       input logic [N*8-1:0] row, input bit lsgn, input string tag);
      bit want, acc;
      @(negedge clk);
      in_valid = vld; in_vec = vec; in_signed = sgn; in_last = last;
      swap_req = swp; w_load_valid = ld; w_row = row; w_signed = lsgn;
      if (vld) begin
         exp_q[tail] = model(vec, sgn, act_t);
         due_q[tail] = cnt + LAT;
         tag_q[tail] = tag;
         tail = (tail + 1) % QD;
      end
      if (ld) begin
         for (int j = 0; j < N; j++) bw[act_t ^ 1][mrow][j] = xt(row[8*j +: 8], lsgn);
         mrow = (mrow + 1) % N;
      end
      want = swp || mpend;
      acc  = want && (vld ? last : !mbatch);
      if (vld) mbatch = !last;
      if (acc) begin
         act_t = act_t ^ 1;
         mrow  = 0;
      end
      mpend = want && !acc;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, '0, 0, 0, 0, 0, '0, 0, "R9");
   endtask

   task automatic send(input logic [N*8-1:0] v, input bit s, input string tag);
      step(1, v, s, 1, 0, 0, '0, 0, tag);
   endtask

   task automatic load(input logic [N*8-1:0] r, input bit s);
      step(0, '0, 0, 0, 0, 1, r, s, "R6");
   endtask

   task automatic swap_now();
      step(0, '0, 0, 0, 1, 0, '0, 0, "R7");
      idle(2 * N);
   endtask

   // result monitor: exact cycle of every result, quiet output otherwise
   always @(negedge clk) begin
      if (mon_on) begin
         if (head != tail && due_q[head] == cnt) begin
            chk(out_valid === 1'b1, "R3", "out_valid at due cycle", {127'd0, out_valid}, 1);
            chk(out_vec === exp_q[head], tag_q[head], "out_vec", out_vec, exp_q[head]);
            head = (head + 1) % QD;
         end else begin
            chk(out_valid === 1'b0, "R3", "out_valid outside due cycle", {127'd0, out_valid}, 0);
            chk(out_vec === '0, "R9", "out_vec while idle", out_vec, '0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R3 watchdog: cycles=%0d expected below %0d", 20000, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      in_valid = 0; in_last = 0; in_signed = 0; in_vec = '0;
      swap_req = 0; w_load_valid = 0; w_signed = 0; w_row = '0;
      repeat (3) @(negedge clk);
      // R1: quiet outputs while held in reset
      chk(out_valid === 1'b0, "R1", "out_valid in reset", {127'd0, out_valid}, 0);
      chk(out_vec === '0, "R1", "out_vec in reset", out_vec, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R1", "out_valid after reset", {127'd0, out_valid}, 0);
      chk(out_vec === '0, "R1", "out_vec after reset", out_vec, '0);
      mon_on = 1'b1;

      // R1: cleared tiles give zero sums
      send(32'h7F80FF01, 1, "R1");
      idle(2);

      // tile A, signed weights, into the shadow bank, then an idle swap (R7)
      for (int r = 0; r < N; r++) load(row_a(r), 1);
      swap_now();

      // table walk: tile B loads underneath (R6), held swap (R8), mixed modes (R4)
      for (int k = 0; k < 12; k++) begin
         string tg;
         tg = (k < 5) ? "R6" : (k == 5) ? "R8" : (k == 6) ? "R7" : "R4";
         step(TBL[k].vld, TBL[k].vec, TBL[k].sgn, TBL[k].last, TBL[k].swp,
              (k < 4), row_b(k), 0, tg);
      end
      idle(2 * N);

      // R5: wide sums without wrap
      for (int r = 0; r < N; r++) load(32'h80808080, 1);
      swap_now();
      send(32'h80808080, 1, "R5");
      send(32'hFFFFFFFF, 0, "R5");
      idle(2);
      for (int r = 0; r < N; r++) load(32'hFFFFFFFF, 0);
      swap_now();
      send(32'hFFFFFFFF, 0, "R5");
      idle(2);

      // R10: partial tile, swap, then a full tile must start again at row 0
      load(32'h03030303, 1);
      load(32'h03030303, 1);
      swap_now();
      send(32'h01020304, 0, "R10");
      idle(2);
      for (int r = 0; r < N; r++) load(row_q(r), 1);
      swap_now();
      send(32'h01FF7F80, 1, "R10");
      send(32'h0A0B0C0D, 0, "R10");
      idle(2 * N + 2);

      chk(head == tail, "R3", "results still owed", 128'(tail - head), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule